// File: doc/BRIEF.md
# Frame-Sync Driven Power and Mode Controller

This block decides the operating state of a voice-band converter channel from the activity of a few of its pins. It watches the transmit frame sync, the receive frame sync, and one pin that serves either as the receive master clock or as a static power-down level. From these it chooses between powered-down, full-duplex and receive-only (half-channel) operation, and it selects which master clock the internal clock generator should follow. It does not synthesize clocks and does not gate any supply.

It also watches the receive bit clock pin. When that pin is held static, the transmit bit clock serves both directions. The level of the static pin then tells the clock generator which master clock frequency to assume.

Each watched pin goes through an activity detector. The detector synchronises the pin into the system clock domain and counts cycles since the last edge. A pin is "toggling" while an edge has been seen within `TIMEOUT` system cycles, and "absent" or "static" otherwise. The default timeout is two 8 kHz frame periods of a 100 MHz system clock. The decision is then registered once before it reaches the outputs.

Top module: `fsync_power_mode_ctl`

## Requirements
- R1: While reset is asserted, `mode_o` is 00, `clk_src_o` is 0, `bclk_shared_o` is 0 and `mclk_2m048_o` is 0.
- R2: When the combined clock/power-down pin is static at level 1, `mode_o` is 00 (powered down), whatever the frame syncs do.
- R3: When neither frame sync is toggling, `mode_o` is 00, whether the combined pin is low, high or toggling.
- R4: When the transmit frame sync is toggling and the combined pin is toggling or static at 0, `mode_o` is 01 (full duplex) and `clk_src_o` is 0 (transmit master clock).
- R5: When the transmit frame sync is absent, the receive frame sync is toggling and the combined pin is toggling or static at 0, `mode_o` is 10 (receive half-channel). In this case `clk_src_o` is 1 (receive master clock) if the combined pin is toggling, and 0 if it is static at 0.
- R6: A pin counts as toggling for at least `TIMEOUT` cycles after its last edge, and as absent no later than `TIMEOUT + SYNC_STAGES + 4` cycles after that edge.
- R7: When the receive bit clock pin is static, `bclk_shared_o` is 1 and `mclk_2m048_o` equals the static level. Level 1 means a 2.048 MHz master clock; level 0 means 1.536 or 1.544 MHz. When that pin toggles, both outputs are 0.
- R8: `mode_o` never takes the value 11, and `clk_src_o` is 0 whenever `mode_o` is not 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_fsync_i | input | 1 | Transmit frame sync pin (asynchronous) |
| rx_fsync_i | input | 1 | Receive frame sync pin (asynchronous) |
| rx_mclk_pd_i | input | 1 | Combined receive master clock / power-down pin |
| rx_bclk_sel_i | input | 1 | Receive bit clock pin, also the frequency select when static |
| mode_o | output | 2 | 00 powered down, 01 full duplex, 10 receive half-channel |
| clk_src_o | output | 1 | 0 transmit master clock, 1 receive master clock |
| bclk_shared_o | output | 1 | 1 when the transmit bit clock serves both directions |
| mclk_2m048_o | output | 1 | Assumed master clock: 1 for 2.048 MHz, 0 for 1.536/1.544 MHz |

## Verification
The bench gives each of the four pins one of three states: toggling at a random half-period, static low, or static high. It lets the detectors settle past the timeout and then compares all outputs with a model of the mode rules. Directed cases cover the combinations that separate the rules:
- combined pin high against active frame syncs, which shows the power-down priority;
- receive frame sync alone, with the combined pin toggling and then held low, which shows the clock source choice;
- no frame sync with the combined pin low, which shows that an active sync is needed.

A further directed case stops the transmit frame sync and samples just inside and just past the timeout window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PMC_DOWN   = 2'b00,
      PMC_FULL   = 2'b01,
      PMC_RXHALF = 2'b10
   } pmc_mode_e;

   localparam int unsigned PMC_NUM_WATCH = 4;
   localparam int unsigned PMC_W_TXFS    = 0;
   localparam int unsigned PMC_W_RXFS    = 1;
   localparam int unsigned PMC_W_PD      = 2;
   localparam int unsigned PMC_W_BCLK    = 3;

   localparam logic PMC_SRC_TX = 1'b0;
   localparam logic PMC_SRC_RX = 1'b1;

endpackage

// File: rtl/pmc_activity_det.sv
module pmc_activity_det #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT     = 25000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic active_o,
   output logic level_o
);

   localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT);

   logic             sampled;
   logic             prev_q;
   logic             edge_seen;
   logic [CNT_W-1:0] idle_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sampled = sig_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chain_q <= '0;
            end else if (SYNC_STAGES == 1) begin
               chain_q <= sig_i;
            end else begin
               chain_q <= {chain_q[SYNC_STAGES-2:0], sig_i};
            end
         end
         assign sampled = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign edge_seen = sampled ^ prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         idle_q <= CNT_MAX;
      end else begin
         prev_q <= sampled;
         if (edge_seen) begin
            idle_q <= '0;
         end else if (idle_q != CNT_MAX) begin
            idle_q <= idle_q + 1'b1;
         end
      end
   end

   assign active_o = (idle_q != CNT_MAX);
   assign level_o  = prev_q;

endmodule

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
   import pmc_pkg::*;
(
   input  logic [PMC_NUM_WATCH-1:0] act_i,
   input  logic [PMC_NUM_WATCH-1:0] lvl_i,
   output pmc_mode_e                mode_d,
   output logic                     src_d,
   output logic                     shared_d,
   output logic                     fast_d
);

   logic any_fs;
   logic pd_high;

   assign any_fs  = act_i[PMC_W_TXFS] | act_i[PMC_W_RXFS];
   assign pd_high = ~act_i[PMC_W_PD] & lvl_i[PMC_W_PD];

   always_comb begin
      mode_d = PMC_DOWN;
      src_d  = PMC_SRC_TX;
      if (!any_fs || pd_high) begin
         mode_d = PMC_DOWN;
      end else if (act_i[PMC_W_TXFS]) begin
         mode_d = PMC_FULL;
      end else begin
         mode_d = PMC_RXHALF;
         src_d  = act_i[PMC_W_PD] ? PMC_SRC_RX : PMC_SRC_TX;
      end
   end

   assign shared_d = ~act_i[PMC_W_BCLK];
   assign fast_d   = ~act_i[PMC_W_BCLK] & lvl_i[PMC_W_BCLK];

endmodule

// File: rtl/fsync_power_mode_ctl.sv
module fsync_power_mode_ctl
   import pmc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT     = 25000
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tx_fsync_i,
   input  logic       rx_fsync_i,
   input  logic       rx_mclk_pd_i,
   input  logic       rx_bclk_sel_i,
   output logic [1:0] mode_o,
   output logic       clk_src_o,
   output logic       bclk_shared_o,
   output logic       mclk_2m048_o
);

   generate
      if (TIMEOUT < 4) begin : g_bad_timeout
         $error("TIMEOUT must be at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic [PMC_NUM_WATCH-1:0] watch_in;
   logic [PMC_NUM_WATCH-1:0] watch_act;
   logic [PMC_NUM_WATCH-1:0] watch_lvl;

   assign watch_in[PMC_W_TXFS] = tx_fsync_i;
   assign watch_in[PMC_W_RXFS] = rx_fsync_i;
   assign watch_in[PMC_W_PD]   = rx_mclk_pd_i;
   assign watch_in[PMC_W_BCLK] = rx_bclk_sel_i;

   generate
      for (genvar gi = 0; gi < PMC_NUM_WATCH; gi++) begin : g_det
         pmc_activity_det #(
            .SYNC_STAGES(SYNC_STAGES),
            .TIMEOUT    (TIMEOUT)
         ) u_det (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sig_i   (watch_in[gi]),
            .active_o(watch_act[gi]),
            .level_o (watch_lvl[gi])
         );
      end
   endgenerate

   pmc_mode_e mode_d;
   logic      src_d;
   logic      shared_d;
   logic      fast_d;

   pmc_mode_decode u_dec (
      .act_i   (watch_act),
      .lvl_i   (watch_lvl),
      .mode_d  (mode_d),
      .src_d   (src_d),
      .shared_d(shared_d),
      .fast_d  (fast_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_o        <= PMC_DOWN;
         clk_src_o     <= PMC_SRC_TX;
         bclk_shared_o <= 1'b0;
         mclk_2m048_o  <= 1'b0;
      end else begin
         mode_o        <= mode_d;
         clk_src_o     <= src_d;
         bclk_shared_o <= shared_d;
         mclk_2m048_o  <= fast_d;
      end
   end

endmodule

// File: rtl/fsync_power_mode_ctl_chk.sv
module fsync_power_mode_ctl_chk
   import pmc_pkg::*;
(
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic [1:0]               mode_o,
   input logic                     clk_src_o,
   input logic                     bclk_shared_o,
   input logic                     mclk_2m048_o,
   input logic [PMC_NUM_WATCH-1:0] act_i,
   input logic [PMC_NUM_WATCH-1:0] lvl_i
);

   assert_mode_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o != 2'b11);

   assert_src_only_rxhalf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_src_o |-> (mode_o == PMC_RXHALF));

   assert_pd_high_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_i[PMC_W_PD] && lvl_i[PMC_W_PD]) |=> (mode_o == PMC_DOWN));

   assert_no_fs_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_i[PMC_W_TXFS] && !act_i[PMC_W_RXFS]) |=> (mode_o == PMC_DOWN));

   assert_full_tx_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[PMC_W_TXFS] && (act_i[PMC_W_PD] || !lvl_i[PMC_W_PD]))
      |=> (mode_o == PMC_FULL && !clk_src_o));

   assert_rxhalf_rx_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_i[PMC_W_TXFS] && act_i[PMC_W_RXFS] && act_i[PMC_W_PD])
      |=> (mode_o == PMC_RXHALF && clk_src_o));

   assert_freq_needs_static_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mclk_2m048_o |-> bclk_shared_o);

endmodule

bind fsync_power_mode_ctl fsync_power_mode_ctl_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_o       (mode_o),
   .clk_src_o    (clk_src_o),
   .bclk_shared_o(bclk_shared_o),
   .mclk_2m048_o (mclk_2m048_o),
   .act_i        (watch_act),
   .lvl_i        (watch_lvl)
);

// File: tb/fsync_power_mode_ctl_tb.sv
module fsync_power_mode_ctl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TO         = 40;
   localparam int SYNC       = 2;
   localparam int SETTLE     = TO + 20;

   logic       clk;
   logic       rst_n;
   logic [3:0] pins;
   logic [1:0] mode;
   logic       src;
   logic       shared;
   logic       fast;

   int  checks   = 0;
   int  failures = 0;
   bit  tog  [4];
   bit  lvl  [4];
   int  half [4];
   int  cnt  [4];

   fsync_power_mode_ctl #(.SYNC_STAGES(SYNC), .TIMEOUT(TO)) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .tx_fsync_i   (pins[0]),
      .rx_fsync_i   (pins[1]),
      .rx_mclk_pd_i (pins[2]),
      .rx_bclk_sel_i(pins[3]),
      .mode_o       (mode),
      .clk_src_o    (src),
      .bclk_shared_o(shared),
      .mclk_2m048_o (fast)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // pin generators: 0 tx fsync, 1 rx fsync, 2 combined pin, 3 rx bit clock
   initial pins = '0;
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (tog[i]) begin
            cnt[i] = cnt[i] + 1;
            if (cnt[i] >= half[i]) begin
               pins[i] = ~pins[i];
               cnt[i]  = 0;
            end
         end else begin
            pins[i] = lvl[i];
         end
      end
   end

   function automatic logic [1:0] exp_mode(bit ftx, bit frx, bit ptog, bit plvl);
      if (!(ftx || frx) || (!ptog && plvl)) return 2'b00;
      if (ftx) return 2'b01;
      return 2'b10;
   endfunction

   function automatic logic exp_src(bit ftx, bit frx, bit ptog, bit plvl);
      return (exp_mode(ftx, frx, ptog, plvl) == 2'b10) && ptog;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic setup(bit t0, bit l0, bit t1, bit l1, bit t2, bit l2, bit t3, bit l3);
      @(posedge clk);
      tog[0] = t0; lvl[0] = l0; tog[1] = t1; lvl[1] = l1;
      tog[2] = t2; lvl[2] = l2; tog[3] = t3; lvl[3] = l3;
      for (int i = 0; i < 4; i++) begin
         half[i] = 1 + int'($urandom_range(5));
         cnt[i]  = 0;
      end
   endtask

   task automatic settle_and_check();
      logic [1:0] em;
      string      tag;
      repeat (SETTLE) @(negedge clk);
      #1;
      em = exp_mode(tog[0], tog[1], tog[2], lvl[2]);
      if (!tog[2] && lvl[2]) tag = "R2";
      else if (!tog[0] && !tog[1]) tag = "R3";
      else if (tog[0]) tag = "R4";
      else tag = "R5";
      check({tag, " mode"}, mode, em);
      check({tag, " R8 clk_src"}, src, exp_src(tog[0], tog[1], tog[2], lvl[2]));
      check("R7 shared", shared, !tog[3]);
      check("R7 freq", fast, !tog[3] && lvl[3]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 4; i++) begin
         tog[i] = 0; lvl[i] = 0; half[i] = 1; cnt[i] = 0;
      end
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 mode", mode, 0);
      check("R1 clk_src", src, 0);
      check("R1 shared", shared, 0);
      check("R1 freq", fast, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      setup(1,0, 1,0, 0,1, 1,0);  settle_and_check(); // R2 pin high, both syncs
      setup(1,0, 0,0, 0,1, 0,1);  settle_and_check(); // R2 pin high, tx only
      setup(0,0, 0,0, 0,0, 0,0);  settle_and_check(); // R3 pin low, no sync
      setup(0,1, 0,1, 1,0, 0,1);  settle_and_check(); // R3 pin toggling, no sync
      setup(1,0, 0,0, 1,0, 0,1);  settle_and_check(); // R4 pin toggling
      setup(1,0, 1,0, 0,0, 0,0);  settle_and_check(); // R4 pin low
      setup(0,0, 1,0, 1,0, 1,0);  settle_and_check(); // R5 rx master clock
      setup(0,1, 1,0, 0,0, 0,1);  settle_and_check(); // R5 pin low -> tx clock

      // R6 timeout window on the transmit frame sync
      setup(1,0, 0,0, 0,0, 0,0);
      half[0] = 1;
      repeat (SETTLE) @(negedge clk);
      @(posedge clk);
      tog[0] = 0;
      lvl[0] = pins[0];
      repeat (TO) @(negedge clk);
      #1;
      check("R6 still active", mode, 1);
      repeat (6) @(negedge clk);
      #1;
      check("R6 absent after timeout", mode, 0);

      // constrained random
      for (int n = 0; n < 80; n++) begin
         setup($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1),
               $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
         settle_and_check();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule